// File: doc/BRIEF.md
# Phase-Error Loss-of-Lock Detector

This block watches two clocks, a reference and a feedback clock, and decides on every comparison cycle whether the feedback clock is still aligned with the reference. Both clock signals pass through a short synchronizer into a much faster sampling clock domain. There, the rising edges of the two clocks are paired, and the number of sampling ticks between the two edges of each pair gives the phase error. Each finished pair yields one error measurement. The measurement carries a magnitude and a flag that says which edge came first.

An `unlocked` output reports loss of lock. It rises when a measurement is larger than a trip threshold. It falls only when a measurement is smaller than a lower clear threshold, so the gap between the two thresholds acts as a hysteresis band. The output is judged again on every measurement and may toggle while the loop settles. The trip, clear and missing-edge limits are ports, all given in sampling ticks. A pair whose partner edge never arrives, or whose window is interrupted by a second edge of the same clock, counts as a saturated error.

Top module: `lock_loss_detector`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `unlocked` is 1, `err_valid` is 0 and `err_mag` is 0.
- R2: For each pair of rising edges, `err_mag` equals their distance in sampling ticks, whichever edge came first. `fb_early` is 1 when the feedback edge came first and 0 when the reference edge came first.
- R3: Each pair produces exactly one `err_valid` pulse, one cycle wide. `err_mag` and `fb_early` are meaningful in the cycle of that pulse.
- R4: A measurement strictly greater than `trip_ticks` sets `unlocked` to 1. A measurement equal to `trip_ticks` does not set it.
- R5: A measurement strictly smaller than `clear_ticks` sets `unlocked` to 0. A measurement equal to `clear_ticks` does not clear it.
- R6: A measurement from `clear_ticks` to `trip_ticks` inclusive leaves `unlocked` unchanged.
- R7: `unlocked` changes only on the clock edge that follows an `err_valid` pulse. It holds at all other times.
- R8: Suppose the partner edge arrives exactly `miss_ticks` ticks after the first edge. It is then paired normally. If the partner has not arrived by then, the block reports a forced measurement with `err_mag` all ones and returns to idle. A partner that arrives later starts a new window.
- R9: Suppose a second rising edge of the same clock arrives while its partner is still awaited. The block then reports a forced all-ones measurement, and the new edge opens a fresh window.
- R10: Rising edges that arrive on the same tick give `err_mag` 0.
- R11: New values on `trip_ticks` and `clear_ticks`, applied while the block is idle, govern the next measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; one tick is one period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock level, asynchronous to clk |
| fb_in | input | 1 | Feedback clock level, asynchronous to clk |
| trip_ticks | input | CNT_W | Error above this sets `unlocked` |
| clear_ticks | input | CNT_W | Error below this clears `unlocked` |
| miss_ticks | input | CNT_W | Longest wait for the partner edge |
| unlocked | output | 1 | 1 = loss of lock, 0 = locked |
| err_mag | output | CNT_W | Edge-to-edge distance in ticks, all ones when forced |
| fb_early | output | 1 | Feedback edge came first |
| err_valid | output | 1 | One-cycle strobe for a new measurement |

## Verification
A pairing state that sits in the wrong wait state shows up one measurement later. The next `err_mag` is then either an unexpected all-ones value or a distance measured from the wrong edge, and `fb_early` has the wrong polarity. A wrong hysteresis decision shows at `unlocked` one cycle after the strobe. The boundary cases where the error equals the trip or clear threshold are the quickest way to expose an off-by-one compare. A counter that ends a window one tick early or one tick late shows up in the exact-limit case, which gives a real distance, and the one-tick-over case, which gives two forced measurements.

// File: rtl/lkd_pkg.sv
`timescale 1ns/1ps
package lkd_pkg;
   // pairing state: idle, or holding one edge while the partner is awaited
   typedef enum logic [1:0] {
      PW_IDLE     = 2'd0,
      PW_WAIT_FB  = 2'd1,
      PW_WAIT_REF = 2'd2
   } pair_state_e;

   localparam int LANE_REF = 0;
   localparam int LANE_FB  = 1;
   localparam int LANES    = 2;
endpackage

// File: rtl/lkd_edge_sync.sv
`timescale 1ns/1ps
module lkd_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic rise
);
   logic prev;
   logic level;

   generate
      if (STAGES > 4) begin : g_bad_depth
         $error("lkd_edge_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_direct
         assign level = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= STAGES'({chain, d});
         end
         assign level = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= level;
   end

   assign rise = level & ~prev;

   // R3
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/lkd_pair_timer.sv
`timescale 1ns/1ps
module lkd_pair_timer
   import lkd_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_rise,
   input  logic             fb_rise,
   input  logic [CNT_W-1:0] miss_ticks,
   output logic             m_valid,
   output logic [CNT_W-1:0] m_mag,
   output logic             m_fb_early
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] SAT = '1;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("lkd_pair_timer: CNT_W must be at least 2");
      end
   endgenerate

   pair_state_e      st, st_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic             emit;
   logic [CNT_W-1:0] e_mag;
   logic             e_fb;

   always_comb begin
      st_n  = st;
      cnt_n = cnt;
      emit  = 1'b0;
      e_mag = '0;
      e_fb  = 1'b0;
      case (st)
         PW_IDLE: begin
            if (ref_rise && fb_rise) begin
               emit = 1'b1;
            end else if (ref_rise) begin
               st_n  = PW_WAIT_FB;
               cnt_n = ONE;
            end else if (fb_rise) begin
               st_n  = PW_WAIT_REF;
               cnt_n = ONE;
            end
         end
         PW_WAIT_FB: begin
            if (fb_rise) begin
               emit  = 1'b1;
               e_mag = cnt;
               if (ref_rise) cnt_n = ONE;
               else          st_n  = PW_IDLE;
            end else if (ref_rise) begin
               emit  = 1'b1;
               e_mag = SAT;
               cnt_n = ONE;
            end else if (cnt >= miss_ticks) begin
               emit  = 1'b1;
               e_mag = SAT;
               st_n  = PW_IDLE;
            end else begin
               cnt_n = cnt + ONE;
            end
         end
         PW_WAIT_REF: begin
            e_fb = 1'b1;
            if (ref_rise) begin
               emit  = 1'b1;
               e_mag = cnt;
               if (fb_rise) cnt_n = ONE;
               else         st_n  = PW_IDLE;
            end else if (fb_rise) begin
               emit  = 1'b1;
               e_mag = SAT;
               cnt_n = ONE;
            end else if (cnt >= miss_ticks) begin
               emit  = 1'b1;
               e_mag = SAT;
               st_n  = PW_IDLE;
            end else begin
               cnt_n = cnt + ONE;
            end
         end
         default: st_n = PW_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= PW_IDLE;
         cnt        <= '0;
         m_valid    <= 1'b0;
         m_mag      <= '0;
         m_fb_early <= 1'b0;
      end else begin
         st         <= st_n;
         cnt        <= cnt_n;
         m_valid    <= emit;
         m_mag      <= emit ? e_mag : m_mag;
         m_fb_early <= emit ? e_fb : m_fb_early;
      end
   end

   // R8
   wait_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != PW_IDLE) |-> (cnt != '0));

   // R10
   idle_same_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PW_IDLE && ref_rise && fb_rise) |=> (m_valid && m_mag == '0));
endmodule

// File: rtl/lkd_hyst_flag.sv
`timescale 1ns/1ps
module lkd_hyst_flag #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             m_valid,
   input  logic [CNT_W-1:0] m_mag,
   input  logic [CNT_W-1:0] trip_ticks,
   input  logic [CNT_W-1:0] clear_ticks,
   output logic             unlocked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked <= 1'b1;
      end else if (m_valid) begin
         if (m_mag > trip_ticks)       unlocked <= 1'b1;
         else if (m_mag < clear_ticks) unlocked <= 1'b0;
      end
   end

   // R7
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(m_valid) |-> $stable(unlocked));

   // R4
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> ($past(m_mag) > $past(trip_ticks)));

   // R5
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(unlocked) |-> ($past(m_mag) < $past(clear_ticks)));
endmodule

// File: rtl/lock_loss_detector.sv
`timescale 1ns/1ps
module lock_loss_detector
   import lkd_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_in,
   input  logic             fb_in,
   input  logic [CNT_W-1:0] trip_ticks,
   input  logic [CNT_W-1:0] clear_ticks,
   input  logic [CNT_W-1:0] miss_ticks,
   output logic             unlocked,
   output logic [CNT_W-1:0] err_mag,
   output logic             fb_early,
   output logic             err_valid
);
   logic [LANES-1:0] lane_in;
   logic [LANES-1:0] lane_rise;

   assign lane_in[LANE_REF] = ref_in;
   assign lane_in[LANE_FB]  = fb_in;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         lkd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (lane_in[g]),
            .rise (lane_rise[g])
         );
      end
   endgenerate

   lkd_pair_timer #(.CNT_W(CNT_W)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_rise  (lane_rise[LANE_REF]),
      .fb_rise   (lane_rise[LANE_FB]),
      .miss_ticks(miss_ticks),
      .m_valid   (err_valid),
      .m_mag     (err_mag),
      .m_fb_early(fb_early)
   );

   lkd_hyst_flag #(.CNT_W(CNT_W)) u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .m_valid    (err_valid),
      .m_mag      (err_mag),
      .trip_ticks (trip_ticks),
      .clear_ticks(clear_ticks),
      .unlocked   (unlocked)
   );
endmodule

// File: tb/lock_loss_detector_bench.sv
`timescale 1ns/1ps
module lock_loss_detector_bench;
   localparam int W = 8;
   localparam int NV = 9;
   localparam int VD [NV] = '{1, 3, 4, 5, 3, 2, 0, 6, 1};
   localparam bit VL [NV] = '{0, 1, 0, 0, 1, 0, 0, 1, 0};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ref_in = 1'b0, fb_in = 1'b0;
   logic [W-1:0] trip_ticks = 8'd4, clear_ticks = 8'd2, miss_ticks = 8'd20;
   logic         unlocked, fb_early, err_valid;
   logic [W-1:0] err_mag;

   always #10 clk = ~clk;

   lock_loss_detector #(.CNT_W(W), .SYNC_STAGES(2)) u_lock_loss_detector (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
      .trip_ticks(trip_ticks), .clear_ticks(clear_ticks), .miss_ticks(miss_ticks),
      .unlocked(unlocked), .err_mag(err_mag), .fb_early(fb_early), .err_valid(err_valid)
   );

   int total = 0, bad = 0;
   bit done = 1'b0;
   int vcount = 0;
   int last_mag = 0, prev_mag = 0;
   bit last_fe = 1'b0, pend = 1'b0;
   logic cap_flag = 1'b1;
   bit exp_flag = 1'b1;

   // measurement monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (pend) begin
         cap_flag = unlocked;
         pend = 1'b0;
      end
      if (err_valid) begin
         vcount++;
         prev_mag = last_mag;
         last_mag = int'(err_mag);
         last_fe  = fb_early;
         pend = 1'b1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model(input int m);
      if (m > int'(trip_ticks))       exp_flag = 1'b1;
      else if (m < int'(clear_ticks)) exp_flag = 1'b0;
   endtask

   task automatic play(input logic [63:0] rp, input logic [63:0] fp, input int len, input int tail);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         ref_in = rp[i];
         fb_in  = fp[i];
      end
      @(negedge clk);
      ref_in = 1'b0;
      fb_in  = 1'b0;
      repeat (tail) @(negedge clk);
   endtask

   task automatic pair_run(input bit fb_lead, input int d, input string tag);
      logic [63:0] lp, fw;
      int base;
      lp = (64'd1 << (d + 3)) - 64'd1;
      fw = lp & ~((64'd1 << d) - 64'd1);
      base = vcount;
      if (fb_lead) play(fw, lp, d + 3, 8);
      else         play(lp, fw, d + 3, 8);
      model(d);
      chk(vcount - base == 1, {tag, " R3 strobe count"}, vcount - base, 1);
      chk(last_mag == d, {tag, " R2 magnitude"}, last_mag, d);
      chk(last_fe == fb_lead, {tag, " R2 lead sign"}, int'(last_fe), int'(fb_lead));
      chk(cap_flag == exp_flag, {tag, " flag"}, int'(cap_flag), int'(exp_flag));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      string vt [NV];
      int base;
      vt = '{"R5", "R6", "R4 R6", "R4", "R6", "R5 R6", "R10 R5", "R4", "R5"};

      // R1 reset state
      repeat (3) @(negedge clk);
      chk(unlocked == 1'b1, "R1 flag in reset", int'(unlocked), 1);
      chk(err_valid == 1'b0, "R1 valid in reset", int'(err_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(unlocked == 1'b1 && err_mag == '0, "R1 after release", int'(unlocked), 1);

      // table of edge distances, walked by one loop
      for (int k = 0; k < NV; k++) pair_run(VL[k], VD[k], vt[k]);

      // R8: partner at exactly the limit pairs normally
      pair_run(1'b0, 20, "R8 exact limit");
      pair_run(1'b0, 1, "R5 reclear");

      // R8: reference alone times out
      base = vcount;
      play(64'h7, 64'h0, 3, 40);
      model(255);
      chk(vcount - base == 1, "R8 lone edge count", vcount - base, 1);
      chk(last_mag == 255, "R8 lone edge forced", last_mag, 255);
      chk(cap_flag == exp_flag, "R8 lone edge flag", int'(cap_flag), int'(exp_flag));

      // R8: partner one tick past the limit -> two forced results
      base = vcount;
      play((64'd1 << 24) - 64'd1, 64'h7 << 21, 24, 40);
      model(255);
      chk(vcount - base == 2, "R8 late partner count", vcount - base, 2);
      chk(prev_mag == 255 && last_mag == 255, "R8 late partner forced", last_mag, 255);
      chk(last_fe == 1'b1, "R8 late partner starts new window", int'(last_fe), 1);

      pair_run(1'b0, 0, "R10 R5");

      // R9: repeated reference edge before the partner
      base = vcount;
      play(64'h63, 64'h180, 9, 10);
      model(255);
      model(2);
      chk(vcount - base == 2, "R9 repeat count", vcount - base, 2);
      chk(prev_mag == 255, "R9 repeat forced", prev_mag, 255);
      chk(last_mag == 2, "R9 new window distance", last_mag, 2);
      chk(cap_flag == exp_flag, "R9 flag", int'(cap_flag), int'(exp_flag));

      // R11: new thresholds while idle
      @(negedge clk);
      trip_ticks  = 8'd10;
      clear_ticks = 8'd8;
      pair_run(1'b1, 9, "R11 R6");
      pair_run(1'b0, 7, "R11 R5");
      pair_run(1'b0, 10, "R11 R4 boundary");
      pair_run(1'b1, 11, "R11 R4");

      // R7: flag holds with no measurement
      repeat (5) @(negedge clk);
      chk(unlocked == exp_flag, "R7 idle hold", int'(unlocked), int'(exp_flag));

      // R1 reset again mid-run
      pair_run(1'b0, 1, "R5 before reset");
      rst_n = 1'b0;
      @(negedge clk);
      chk(unlocked == 1'b1 && err_valid == 1'b0, "R1 reapplied", int'(unlocked), 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule